// File: doc/BRIEF.md
# Guarded 64-bit BAR Decoder

This block holds one 64-bit memory base address register pair in an endpoint's configuration space, together with the address decoder that it feeds. Configuration accesses reach it one dword at a time, each carrying a dword index, write data and a write strobe. Reads are combinational on the selected dword. The aperture size is a fixed power of two, set by a parameter. The address bits below that size read back as zero, so sizing by writing all ones works the usual way.

Each 32-bit half keeps its own programming state. A write of all ones marks a half as sizing. Any other value marks it as addressing. When a write leaves both halves in the same state, both return to settled, and the decode window is loaded from the register contents. At every other time the window keeps its previous base and valid flag. Host software sizes and programs the pair in four writes: ones to the low half, the address to the low half, ones to the high half, then the address to the high half. With this rule, the transient value left after the first write never becomes a live window.

The window is exposed as a base, a valid flag and a hit output for a 64-bit transaction address.

Top module: `bar64_guard`

## Requirements
- R1: After reset, the low half reads 0x0000000C with the default parameters, the high half reads 0, `win_valid` is 0 and `txn_hit` is 0.
- R2: Low-half bits [3:0] ignore writes. Bit 0 reads 0, bits [2:1] read 2'b10 and bit 3 reads the PREFETCH parameter, which defaults to 1.
- R3: Register bits below SIZE_LOG2 ignore writes. Writing all ones to the low half of a 32 MB aperture reads back 0xFE00000C, and writing all ones to the high half reads back 0xFFFFFFFF.
- R4: A half written with 0xFFFFFFFF enters the sizing state, and a half written with any other value enters the addressing state. Halves in different states do not load the window.
- R5: On the write that leaves both halves in the same state, the window loads the new register value. `win_base` and `win_valid` show it one clock after that write.
- R6: On every other write, and when no write occurs, `win_base` and `win_valid` keep their values, and hits follow the previous window.
- R7: `txn_hit` is 1 exactly when `mem_en` is 1, `win_valid` is 1 and (`txn_addr` AND NOT(2^SIZE_LOG2−1)) equals `win_base`.
- R8: With `mem_en` low, `txn_hit` is 0.
- R9: The low half is dword 4+SLOT and the high half is dword 5+SLOT. Writes to any other dword change nothing, and reads of any other dword return 0.
- R10: If both halves are written with all ones, the window loads the sizing value, which is 0xFFFFFFFF_FE000000 for 32 MB.
- R11: Over the four-write sequence for a 32 MB aperture at 0xF0000000, the address 0xFE000000 never hits, and after the fourth write addresses in [0xF0000000, 0xF2000000) hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_dw | input | DW_W | Configuration dword index |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read data for the dword selected by `cfg_dw` |
| mem_en | input | 1 | Memory space decode enable |
| txn_addr | input | 64 | Transaction address to decode |
| txn_hit | output | 1 | Transaction address falls in the live window |
| win_valid | output | 1 | Live window has been loaded |
| win_base | output | 64 | Live window base address |

## Verification
The main vector table runs the four-write sequence for a 32 MB aperture at 0xF0000000. After each step it probes the transient sizing address 0xFE000000 or the target base, which separates a window that follows the register from one that waits for both halves. Directed tests then write a single half to a new address and check that the old window stays in force. A mismatched pair, with ones in one half and an address in the other, must also leave the window alone. The tests then write both halves with ones, write to neighbouring dwords, and probe just inside and just outside the aperture edges, including an address whose upper 32 bits differ. Together these separate a commit on equal states from a commit on any write, and show that the decode masks the correct bits.

// File: rtl/bar64_pkg.sv
package bar64_pkg;

    typedef enum logic [1:0] {
        HS_SETTLED    = 2'd0,
        HS_SIZING     = 2'd1,
        HS_ADDRESSING = 2'd2
    } half_state_e;

    typedef struct packed {
        logic is_lo;
        logic is_hi;
    } slot_sel_t;

    localparam int BAR_AREA_FIRST_DW = 4;
    localparam int BAR_AREA_DWORDS   = 6;

    function automatic logic [63:0] size_mask(input int log2);
        return (64'd1 << log2) - 64'd1;
    endfunction

    function automatic half_state_e classify(input logic [31:0] data);
        return (&data) ? HS_SIZING : HS_ADDRESSING;
    endfunction

endpackage

// File: rtl/bar_slot_decode.sv
module bar_slot_decode
    import bar64_pkg::*;
#(
    parameter int DW_W = 6,
    parameter int SLOT = 0
) (
    input  logic [DW_W-1:0] dw,
    output slot_sel_t       sel
);
    localparam int LO_DW = BAR_AREA_FIRST_DW + SLOT;
    localparam int HI_DW = LO_DW + 1;

    always_comb begin
        sel.is_lo = (dw == DW_W'(LO_DW));
        sel.is_hi = (dw == DW_W'(HI_DW));
    end
endmodule

// File: rtl/bar_half_tracker.sv
module bar_half_tracker
    import bar64_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    output half_state_e st_lo,
    output half_state_e st_hi,
    output logic        commit
);
    half_state_e nxt_lo, nxt_hi;

    always_comb begin
        nxt_lo = wr_lo ? classify(wdata) : st_lo;
        nxt_hi = wr_hi ? classify(wdata) : st_hi;
        commit = (wr_lo || wr_hi) && (nxt_lo == nxt_hi);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_lo <= HS_SETTLED;
            st_hi <= HS_SETTLED;
        end else if (commit) begin
            st_lo <= HS_SETTLED;
            st_hi <= HS_SETTLED;
        end else begin
            st_lo <= nxt_lo;
            st_hi <= nxt_hi;
        end
    end
endmodule

// File: rtl/bar_window.sv
module bar_window
    import bar64_pkg::*;
#(
    parameter int SIZE_LOG2 = 25
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        commit,
    input  logic [63:0] new_base,
    input  logic        mem_en,
    input  logic [63:0] addr,
    output logic        valid,
    output logic [63:0] base,
    output logic        hit
);
    localparam logic [63:0] KEEP = ~size_mask(SIZE_LOG2);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            base  <= '0;
        end else if (commit) begin
            valid <= 1'b1;
            base  <= new_base & KEEP;
        end
    end

    always_comb hit = mem_en && valid && ((addr & KEEP) == base);
endmodule

// File: rtl/bar64_guard.sv
module bar64_guard
    import bar64_pkg::*;
#(
    parameter int   DW_W      = 6,
    parameter int   SLOT      = 0,
    parameter int   SIZE_LOG2 = 25,
    parameter logic PREFETCH  = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_wr,
    input  logic [DW_W-1:0] cfg_dw,
    input  logic [31:0]     cfg_wdata,
    output logic [31:0]     cfg_rdata,
    input  logic            mem_en,
    input  logic [63:0]     txn_addr,
    output logic            txn_hit,
    output logic            win_valid,
    output logic [63:0]     win_base
);
    localparam logic [63:0] WMASK   = ~size_mask(SIZE_LOG2) & ~64'hF;
    localparam logic [3:0]  RO_BITS = {PREFETCH, 2'b10, 1'b0};

    slot_sel_t   sel;
    logic        wr_lo, wr_hi, commit;
    logic [63:0] bar_q, bar_d;
    half_state_e st_lo, st_hi;

    bar_slot_decode #(.DW_W(DW_W), .SLOT(SLOT)) u_dec (
        .dw  (cfg_dw),
        .sel (sel)
    );

    always_comb begin
        wr_lo = cfg_wr && sel.is_lo;
        wr_hi = cfg_wr && sel.is_hi;
        bar_d = bar_q;
        if (wr_lo) bar_d[31:0]  = cfg_wdata & WMASK[31:0];
        if (wr_hi) bar_d[63:32] = cfg_wdata & WMASK[63:32];
    end

    always_ff @(posedge clk) begin
        if (rst) bar_q <= '0;
        else     bar_q <= bar_d;
    end

    bar_half_tracker u_trk (
        .clk    (clk),
        .rst    (rst),
        .wr_lo  (wr_lo),
        .wr_hi  (wr_hi),
        .wdata  (cfg_wdata),
        .st_lo  (st_lo),
        .st_hi  (st_hi),
        .commit (commit)
    );

    bar_window #(.SIZE_LOG2(SIZE_LOG2)) u_win (
        .clk      (clk),
        .rst      (rst),
        .commit   (commit),
        .new_base (bar_d),
        .mem_en   (mem_en),
        .addr     (txn_addr),
        .valid    (win_valid),
        .base     (win_base),
        .hit      (txn_hit)
    );

    always_comb begin
        if (sel.is_lo)      cfg_rdata = bar_q[31:0] | {28'd0, RO_BITS};
        else if (sel.is_hi) cfg_rdata = bar_q[63:32];
        else                cfg_rdata = '0;
    end
endmodule

// File: rtl/bar64_guard_chk.sv
module bar64_guard_chk
    import bar64_pkg::*;
#(
    parameter int   DW_W     = 6,
    parameter int   SLOT     = 0,
    parameter logic PREFETCH = 1'b1
) (
    input logic            clk,
    input logic            rst,
    input logic [DW_W-1:0] cfg_dw,
    input logic [31:0]     cfg_rdata,
    input logic            mem_en,
    input logic            txn_hit,
    input logic            win_valid,
    input logic [63:0]     win_base,
    input logic            commit,
    input half_state_e     st_lo,
    input half_state_e     st_hi
);
    localparam int LO_DW = BAR_AREA_FIRST_DW + SLOT;

    // R2: read-only low bits
    a_r2_ro_bits: assert property (@(posedge clk) disable iff (rst)
        (cfg_dw == DW_W'(LO_DW)) |-> (cfg_rdata[3:0] == {PREFETCH, 2'b10, 1'b0}));

    // R4: two halves in the same partial state never persist
    a_r4_no_equal_partial: assert property (@(posedge clk) disable iff (rst)
        (st_lo != HS_SETTLED || st_hi != HS_SETTLED) |-> (st_lo != st_hi));

    // R5: a commit leaves the window valid
    a_r5_commit_valid: assert property (@(posedge clk) disable iff (rst)
        commit |=> win_valid);

    // R6: without a commit the window holds
    a_r6_window_hold: assert property (@(posedge clk) disable iff (rst)
        !commit |=> ($stable(win_base) && $stable(win_valid)));

    // R7: a hit needs a valid window
    a_r7_hit_needs_valid: assert property (@(posedge clk) disable iff (rst)
        txn_hit |-> win_valid);

    // R8: decode disabled means no hit
    a_r8_no_hit_disabled: assert property (@(posedge clk) disable iff (rst)
        !mem_en |-> !txn_hit);
endmodule

bind bar64_guard bar64_guard_chk #(.DW_W(DW_W), .SLOT(SLOT), .PREFETCH(PREFETCH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_dw    (cfg_dw),
    .cfg_rdata (cfg_rdata),
    .mem_en    (mem_en),
    .txn_hit   (txn_hit),
    .win_valid (win_valid),
    .win_base  (win_base),
    .commit    (commit),
    .st_lo     (st_lo),
    .st_hi     (st_hi)
);

// File: tb/sim_bar64_guard.sv
module sim_bar64_guard;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [5:0]  cfg_dw = 6'd4;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        mem_en = 1'b1;
    logic [63:0] txn_addr = '0;
    logic        txn_hit;
    logic        win_valid;
    logic [63:0] win_base;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bar64_guard u0 (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_dw(cfg_dw),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_en(mem_en),
        .txn_addr(txn_addr), .txn_hit(txn_hit), .win_valid(win_valid),
        .win_base(win_base)
    );

    // {dw, data, probe address, expected hit, expected valid}
    localparam int NV = 4;
    localparam logic [103:0] VEC [NV] = '{
        {6'd4, 32'hFFFF_FFFF, 64'h0000_0000_FE00_0000, 1'b0, 1'b0},
        {6'd4, 32'hF000_0000, 64'h0000_0000_F000_0000, 1'b0, 1'b0},
        {6'd5, 32'hFFFF_FFFF, 64'h0000_0000_FE00_0000, 1'b0, 1'b0},
        {6'd5, 32'h0000_0000, 64'h0000_0000_F000_0000, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] dw, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_dw = dw; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] dw, input logic [31:0] exp, input string req);
        cfg_dw = dw; #1;
        chk(req, {32'd0, cfg_rdata}, {32'd0, exp});
    endtask

    task automatic probe(input logic [63:0] a, input logic exp, input string req);
        txn_addr = a; #1;
        chk(req, {63'd0, txn_hit}, {63'd0, exp});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(6'd4, 32'h0000_000C, "R1 lo");
        rd(6'd5, 32'h0, "R1 hi");
        chk("R1 valid", {63'd0, win_valid}, 64'd0);
        probe(64'h0, 1'b0, "R1 hit");

        // R11 four-write sequence, no hit at transient sizing address
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][103:98], VEC[i][97:66]);
            probe(VEC[i][65:2], VEC[i][1], "R11 step hit");
            probe(64'h0000_0000_FE00_0000, 1'b0, "R11 no sizing hit");
            chk("R11 step valid", {63'd0, win_valid}, {63'd0, VEC[i][0]});
            if (i == 0) rd(6'd4, 32'hFE00_000C, "R3 lo sizing readback");
        end
        chk("R5 base", win_base, 64'h0000_0000_F000_0000);

        // R7 aperture edges
        probe(64'h0000_0000_F1FF_FFFF, 1'b1, "R7 top inside");
        probe(64'h0000_0000_F200_0000, 1'b0, "R7 above");
        probe(64'h0000_0000_EFFF_FFFF, 1'b0, "R7 below");
        probe(64'h0000_0001_F000_0000, 1'b0, "R7 upper bits differ");

        // R8 decode disable
        mem_en = 1'b0;
        probe(64'h0000_0000_F000_0000, 1'b0, "R8 disabled");
        mem_en = 1'b1;

        // R9 other dwords
        wr(6'd6, 32'h1234_5678);
        wr(6'd3, 32'hABCD_EF01);
        rd(6'd4, 32'hF000_000C, "R9 lo untouched");
        rd(6'd5, 32'h0, "R9 hi untouched");
        rd(6'd6, 32'h0, "R9 other reads zero");
        chk("R9 window", win_base, 64'h0000_0000_F000_0000);

        // R6 single half write holds window; R2 read-only bits
        wr(6'd4, 32'h4000_0003);
        rd(6'd4, 32'h4000_000C, "R2 ro bits");
        chk("R6 hold base", win_base, 64'h0000_0000_F000_0000);
        probe(64'h0000_0000_F000_0000, 1'b1, "R6 old window hit");
        probe(64'h0000_0000_4000_0000, 1'b0, "R6 new not live");
        wr(6'd5, 32'h0);
        chk("R5 commit base", win_base, 64'h0000_0000_4000_0000);

        // R4 mismatched states do not commit
        wr(6'd4, 32'hFFFF_FFFF);
        wr(6'd5, 32'h0000_0001);
        chk("R4 no commit", win_base, 64'h0000_0000_4000_0000);
        rd(6'd5, 32'h0000_0001, "R4 hi readback");
        wr(6'd4, 32'h8000_0000);
        chk("R4 commit", win_base, 64'h0000_0001_8000_0000);
        probe(64'h0000_0001_8100_0000, 1'b1, "R4 hit");

        // R10 sizing pair commits sizing value; R3 hi readback
        wr(6'd4, 32'hFFFF_FFFF);
        wr(6'd5, 32'hFFFF_FFFF);
        chk("R10 base", win_base, 64'hFFFF_FFFF_FE00_0000);
        rd(6'd5, 32'hFFFF_FFFF, "R3 hi sizing readback");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule